// File: doc/BRIEF.md
# Two-Priority Process Scheduler

This block picks which process runs next on a processor that has two priority levels. Each process is known only by its workspace address. The block keeps two ready queues, one per priority. Each queue is a singly linked list threaded through a small link memory that the block owns, holding one link word per workspace, and each queue is tracked by a front register and a back register. A high-priority process keeps the processor until it stops or blocks. Low-priority processes take turns, one timeslice each.

Surrounding logic drives three kinds of request:
- an enqueue, carrying a workspace address and a priority, when a process becomes ready;
- a stop, when the running process finishes or blocks on input, output or a timer;
- a periodic timeslice tick.

When a high-priority process arrives while a low-priority one is running, the low-priority process is set aside in a single shadow slot. It resumes once no high-priority work is left. The block reports the running workspace, its priority and a valid flag. A busy output holds off new requests for the one cycle a list update needs to fetch a link word.

Top module: `proc_sched`

## Requirements
- R1: After synchronous reset, run_valid and busy are 0.
- R2: Workspace addresses are nonzero; the value 0 is the reserved empty-queue marker and is never enqueued. An enqueue accepted while run_valid is 0 makes that workspace the running one at the accepting clock edge, with run_hi equal to enq_hi (1 = high, 0 = low).
- R3: Within one priority, queued workspaces leave their queue in the order they entered it (first in, first out).
- R4: An enqueue with enq_hi=1 while a low-priority process runs preempts it at once. The preempted workspace resumes only when the high queue is empty and the running high process stops.
- R5: A tick while a high-priority process runs has no effect.
- R6: A tick while a low-priority process runs and the low queue is non-empty moves the running workspace to the back of the low queue and starts the low queue's front. With the low queue empty, the tick has no effect.
- R7: On stop, the next process is chosen in this order: high queue front, then the preempted low process, then low queue front. If none exists, run_valid drops to 0.
- R8: A dequeue that leaves a non-empty queue raises busy for exactly the one following cycle, and requests presented while busy is 1 are ignored. A dequeue that empties its queue, and every enqueue, leave busy at 0.
- R9: When several requests arrive in the same accepted cycle, stop wins over enqueue, and enqueue wins over tick; the losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request |
| enq_ws | input | WS_W | Workspace address to enqueue (nonzero) |
| enq_hi | input | 1 | Priority of the enqueued process, 1 = high |
| stop | input | 1 | Running process stops or blocks |
| tick | input | 1 | Timeslice expiry |
| busy | output | 1 | List update in progress; requests ignored |
| run_valid | output | 1 | A process is running |
| run_ws | output | WS_W | Running workspace address |
| run_hi | output | 1 | Running process priority, 1 = high |

## Verification
Every accepted request changes run_valid, run_ws and run_hi at the same clock edge that accepts it. A dequeue that leaves entries behind also raises busy for the next cycle only. The bench drives each request on a falling edge and releases it one falling edge later, where it samples the run outputs and busy. It waits out busy before the next request, except when it deliberately presents a request during busy to show that the request is dropped. Queue order and dropped requests are observed at the ports by draining each queue with stops until run_valid falls.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic {ST_IDLE, ST_FIX} sched_st_e;
  localparam int QLO = 0;
  localparam int QHI = 1;
endpackage

// File: rtl/sched_link_ram.sv
module sched_link_ram #(
  parameter int AW = 6,
  parameter int DW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sched_queue.sv
module sched_queue #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         sb,
  input  logic         sf,
  input  logic [W-1:0] val,
  output logic [W-1:0] front,
  output logic [W-1:0] back,
  output logic         empty
);
  localparam logic [W-1:0] NULL_WS = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      front <= NULL_WS;
      back  <= NULL_WS;
    end else if (ld) begin
      front <= val;
      back  <= val;
    end else if (sb) begin
      back  <= val;
    end else if (sf) begin
      front <= val;
    end
  end

  assign empty = (front == NULL_WS);

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld, sb, sf})); // R3
  AST_APPEND_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    sb |-> !empty); // R3
endmodule

// File: rtl/proc_sched.sv
module proc_sched #(
  parameter int WS_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enq_valid,
  input  logic [WS_W-1:0] enq_ws,
  input  logic            enq_hi,
  input  logic            stop,
  input  logic            tick,
  output logic            busy,
  output logic            run_valid,
  output logic [WS_W-1:0] run_ws,
  output logic            run_hi
);
  import sched_pkg::*;

  localparam logic [WS_W-1:0] NULL_WS = '0;
  localparam int NQ = 2;

  logic [WS_W-1:0] q_front [NQ];
  logic [WS_W-1:0] q_back  [NQ];
  logic [WS_W-1:0] q_val   [NQ];
  logic [NQ-1:0]   q_empty, q_ld, q_sb, q_sf;

  logic            mem_we;
  logic [WS_W-1:0] mem_wa, mem_wd, rd_addr, rd_data;

  sched_st_e       st_q, st_d;
  logic            fix_q, fix_d;
  logic            run_v_q, run_v_d, run_hi_q, run_hi_d, sh_v_q, sh_v_d;
  logic [WS_W-1:0] run_ws_q, run_ws_d, sh_ws_q, sh_ws_d;
  logic            take, tp, ep, accept, do_stop, do_enq, do_tick;

  for (genvar p = 0; p < NQ; p++) begin : g_q
    sched_queue #(.W(WS_W)) u_q (
      .clk   (clk),
      .rst   (rst),
      .ld    (q_ld[p]),
      .sb    (q_sb[p]),
      .sf    (q_sf[p]),
      .val   (q_val[p]),
      .front (q_front[p]),
      .back  (q_back[p]),
      .empty (q_empty[p])
    );
  end

  sched_link_ram #(.AW(WS_W), .DW(WS_W)) u_links (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_wa),
    .wdata (mem_wd),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  assign accept  = (st_q == ST_IDLE);
  assign do_stop = accept && stop;
  assign do_enq  = accept && enq_valid && !stop;
  assign do_tick = accept && tick && !stop && !enq_valid;

  always_comb begin
    st_d     = st_q;
    fix_d    = fix_q;
    run_v_d  = run_v_q;
    run_ws_d = run_ws_q;
    run_hi_d = run_hi_q;
    sh_v_d   = sh_v_q;
    sh_ws_d  = sh_ws_q;
    q_ld     = '0;
    q_sb     = '0;
    q_sf     = '0;
    q_val[0] = NULL_WS;
    q_val[1] = NULL_WS;
    mem_we   = 1'b0;
    mem_wa   = NULL_WS;
    mem_wd   = NULL_WS;
    rd_addr  = NULL_WS;
    take     = 1'b0;
    tp       = 1'b0;
    ep       = enq_hi;

    if (st_q == ST_FIX) begin
      // second half of a dequeue: the fetched link becomes the new front
      q_sf[fix_q]  = 1'b1;
      q_val[fix_q] = rd_data;
      st_d         = ST_IDLE;
    end else if (do_stop) begin
      if (!q_empty[QHI]) begin
        take = 1'b1;
        tp   = 1'b1;
      end else if (sh_v_q) begin
        run_ws_d = sh_ws_q;
        run_hi_d = 1'b0;
        sh_v_d   = 1'b0;
      end else if (!q_empty[QLO]) begin
        take = 1'b1;
        tp   = 1'b0;
      end else begin
        run_v_d = 1'b0;
      end
    end else if (do_enq) begin
      if (!run_v_q) begin
        run_v_d  = 1'b1;
        run_ws_d = enq_ws;
        run_hi_d = enq_hi;
      end else if (enq_hi && !run_hi_q) begin
        sh_v_d   = 1'b1;
        sh_ws_d  = run_ws_q;
        run_ws_d = enq_ws;
        run_hi_d = 1'b1;
      end else begin
        q_val[ep] = enq_ws;
        if (q_empty[ep]) begin
          q_ld[ep] = 1'b1;
        end else begin
          q_sb[ep] = 1'b1;
          mem_we   = 1'b1;
          mem_wa   = q_back[ep];
          mem_wd   = enq_ws;
        end
      end
    end else if (do_tick && run_v_q && !run_hi_q && !q_empty[QLO]) begin
      run_ws_d   = q_front[QLO];
      q_val[QLO] = run_ws_q;
      if (q_front[QLO] == q_back[QLO]) begin
        q_ld[QLO] = 1'b1;
      end else begin
        q_sb[QLO] = 1'b1;
        mem_we    = 1'b1;
        mem_wa    = q_back[QLO];
        mem_wd    = run_ws_q;
        rd_addr   = q_front[QLO];
        st_d      = ST_FIX;
        fix_d     = 1'b0;
      end
    end

    if (take) begin
      run_v_d  = 1'b1;
      run_ws_d = q_front[tp];
      run_hi_d = tp;
      if (q_front[tp] == q_back[tp]) begin
        q_sf[tp]  = 1'b1;
        q_val[tp] = NULL_WS;
      end else begin
        rd_addr = q_front[tp];
        st_d    = ST_FIX;
        fix_d   = tp;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      fix_q    <= 1'b0;
      run_v_q  <= 1'b0;
      run_ws_q <= NULL_WS;
      run_hi_q <= 1'b0;
      sh_v_q   <= 1'b0;
      sh_ws_q  <= NULL_WS;
    end else begin
      st_q     <= st_d;
      fix_q    <= fix_d;
      run_v_q  <= run_v_d;
      run_ws_q <= run_ws_d;
      run_hi_q <= run_hi_d;
      sh_v_q   <= sh_v_d;
      sh_ws_q  <= sh_ws_d;
    end
  end

  assign busy      = (st_q == ST_FIX);
  assign run_valid = run_v_q;
  assign run_ws    = run_ws_q;
  assign run_hi    = run_hi_q;

  AST_IDLE_CLEAN: assert property (@(posedge clk) disable iff (rst)
    !run_v_q |-> (q_empty == 2'b11) && !sh_v_q); // R7
  AST_SHADOW_UNDER_HI: assert property (@(posedge clk) disable iff (rst)
    sh_v_q |-> run_v_q && run_hi_q); // R4
  AST_HIQ_UNDER_HI: assert property (@(posedge clk) disable iff (rst)
    !q_empty[QHI] |-> run_v_q && run_hi_q); // R4
  AST_BUSY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy); // R8
  AST_HI_NO_SLICE: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop && !enq_valid && !busy && run_v_q && run_hi_q)
      |=> $stable(run_ws_q) && run_hi_q); // R5
endmodule

// File: tb/tb_proc_sched.sv
module tb_proc_sched;
  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         enq_valid = 1'b0, enq_hi = 1'b0, stop = 1'b0, tick = 1'b0;
  logic [W-1:0] enq_ws = '0;
  logic         busy, run_valid, run_hi;
  logic [W-1:0] run_ws;
  int           n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  proc_sched #(.WS_W(W)) dut (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_ws(enq_ws),
    .enq_hi(enq_hi), .stop(stop), .tick(tick), .busy(busy),
    .run_valid(run_valid), .run_ws(run_ws), .run_hi(run_hi)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_run(input string tag, input int v, input int ws, input int hi);
    chk(tag, "run_valid", int'(run_valid), v);
    if (v != 0) begin
      chk(tag, "run_ws", int'(run_ws), ws);
      chk(tag, "run_hi", int'(run_hi), hi);
    end
  endtask

  // drive at a falling edge, release and sample at the next one
  task automatic pulse(input logic s, input logic e, input logic t,
                       input logic [W-1:0] ws, input logic hi);
    stop = s; enq_valid = e; tick = t; enq_ws = ws; enq_hi = hi;
    @(negedge clk);
    stop = 1'b0; enq_valid = 1'b0; tick = 1'b0;
  endtask

  task automatic settle;
    while (busy) @(negedge clk);
  endtask

  task automatic enq(input logic [W-1:0] ws, input logic hi);
    pulse(1'b0, 1'b1, 1'b0, ws, hi); settle();
  endtask

  task automatic stp;
    pulse(1'b1, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic tck;
    pulse(1'b0, 1'b0, 1'b1, '0, 1'b0);
  endtask

  task automatic t_reset;
    chk_run("R1", 0, 0, 0);
    chk("R1", "busy", int'(busy), 0);
  endtask

  task automatic t_fifo;
    enq(5, 0);  chk_run("R2", 1, 5, 0);
    enq(6, 0);  chk("R8", "busy after enqueue", int'(busy), 0);
    enq(7, 0);  enq(8, 0);
    chk_run("R3 queued", 1, 5, 0);
    stp();      chk_run("R3", 1, 6, 0);
    chk("R8", "busy after dequeue", int'(busy), 1);
    pulse(1'b0, 1'b1, 1'b0, 9, 1'b1);   // presented while busy: dropped
    chk("R8", "busy one cycle", int'(busy), 0);
    chk_run("R8 ignored", 1, 6, 0);
    stp();      chk_run("R3", 1, 7, 0); settle();
    stp();      chk_run("R3", 1, 8, 0);
    chk("R8", "busy on last entry", int'(busy), 0);
    stp();      chk_run("R7 empty", 0, 0, 0);
  endtask

  task automatic t_preempt;
    enq(10, 0); enq(11, 0);
    enq(20, 1); chk_run("R4 preempt", 1, 20, 1);
    enq(21, 1); chk_run("R4 queued hi", 1, 20, 1);
    tck();      chk_run("R5", 1, 20, 1);
    stp();      chk_run("R7 hi first", 1, 21, 1); settle();
    stp();      chk_run("R4 resume", 1, 10, 0); settle();
    stp();      chk_run("R7 low queue", 1, 11, 0); settle();
    stp();      chk_run("R7 idle", 0, 0, 0);
  endtask

  task automatic t_slice;
    enq(30, 0);
    tck();      chk_run("R6 empty queue", 1, 30, 0);
    enq(31, 0); enq(32, 0);
    tck();      chk_run("R6 rotate", 1, 31, 0); settle();
    tck();      chk_run("R6 rotate", 1, 32, 0); settle();
    stp();      chk_run("R6 order", 1, 30, 0); settle();
    stp();      chk_run("R6 order", 1, 31, 0); settle();
    stp();      chk_run("R6 drained", 0, 0, 0);
  endtask

  task automatic t_simul;
    enq(40, 0);
    pulse(1'b1, 1'b1, 1'b1, 41, 1'b0);
    chk_run("R9 stop wins", 0, 0, 0);
    enq(42, 0); enq(43, 0);
    pulse(1'b0, 1'b1, 1'b1, 44, 1'b0);
    chk_run("R9 enqueue over tick", 1, 42, 0); settle();
    stp();      chk_run("R9", 1, 43, 0); settle();
    stp();      chk_run("R9", 1, 44, 0); settle();
    stp();      chk_run("R9", 0, 0, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_fifo();
    t_preempt();
    t_slice();
    t_simul();
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule